// File: doc/BRIEF.md
# Frame-Position Toggle Waveform Generator

This block drives one general-purpose timing waveform inside an image-sensor timing engine. The surrounding engine supplies running field, line and pixel counters. The block compares them against a small set of programmed toggle points. Each point is a three-level coordinate, and the output bit inverts whenever the counters reach one of the enabled points. Software-side logic programs the points through a simple addressed write port.

Writes land in a shadow bank. The comparators work only from an active bank, and that bank is refreshed from the shadow copy on the vertical-sync strobe. A waveform can therefore be reprogrammed at any time during a field without glitching the field in progress. Each vertical-sync strobe also returns the output to low, so every field starts from a known level.

Top module: `gp_toggle_gen`

## Requirements
- R1: After reset, the output is low and every shadow and active coordinate and enable bit is zero, so no point can toggle until it is programmed, enabled and transferred.
- R2: A write with address 3*k+c loads coordinate c (0 field, 1 line, 2 pixel) of point k into the shadow bank. Address 3*NUM_PTS (12 by default) loads the per-point enable mask from the low data bits, with bit k enabling point k. Writes to higher addresses change nothing.
- R3: Shadow contents reach the active bank only on a clock with the vertical-sync strobe high. A write issued in that same cycle stays in the shadow bank until the next strobe.
- R4: When field, line and pixel counters all equal an enabled active point, the output inverts. Disabled points never cause a toggle.
- R5: On a clock with the vertical-sync strobe high, the output goes low, even if the counters also match a point.
- R6: When several enabled points hold identical coordinates, the output inverts only once at that position.
- R7: In any cycle with no strobe and no match, the output holds its value.
- R8: The output is registered: the effect of a match or a strobe is visible after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync | input | 1 | Vertical-sync strobe; transfers shadow to active and clears output |
| fld_cnt | input | COORD_W | Current field counter |
| line_cnt | input | COORD_W | Current line counter |
| pix_cnt | input | COORD_W | Current pixel counter |
| wr_en | input | 1 | Shadow write strobe |
| wr_addr | input | ADDR_W | Shadow write address |
| wr_data | input | COORD_W | Shadow write data |
| wave_out | output | 1 | Registered toggle waveform |

## Verification
The bench builds the block with its defaults: four points and 13-bit coordinates, which gives a 4-bit address. These values let it place one point at the top of the coordinate range (line and pixel 8191) and reach the unused addresses 13 to 15. They also allow a duplicate pair among the four points. A model in the bench tracks both banks. It predicts the output for every cycle, including a write coinciding with the strobe and a strobe coinciding with a match.

// File: rtl/gp_toggle_pkg.sv
package gp_toggle_pkg;

   // Coordinate selector within one toggle point; the address map uses this order.
   typedef enum logic [1:0] {
      CRD_FIELD = 2'd0,
      CRD_LINE  = 2'd1,
      CRD_PIXEL = 2'd2
   } coord_sel_e;

   localparam int NUM_CRD = 3;

   // Address of coordinate c of point k.
   function automatic int crd_addr(input int k, input int c);
      return NUM_CRD * k + c;
   endfunction

endpackage

// File: rtl/gp_shadow_bank.sv
module gp_shadow_bank
   import gp_toggle_pkg::*;
#(
   parameter int NUM_PTS = 4,
   parameter int COORD_W = 13,
   parameter int ADDR_W  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       vsync,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [COORD_W-1:0]         wr_data,
   output logic [NUM_PTS*COORD_W-1:0] act_fld,
   output logic [NUM_PTS*COORD_W-1:0] act_lin,
   output logic [NUM_PTS*COORD_W-1:0] act_pix,
   output logic [NUM_PTS-1:0]         act_en
);

   localparam int EN_ADDR = NUM_CRD * NUM_PTS;

   logic [NUM_PTS*COORD_W-1:0] sh_fld, sh_lin, sh_pix;
   logic [NUM_PTS-1:0]         sh_en;

   if (EN_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("gp_shadow_bank: ADDR_W too narrow for the enable address");
   end
   if (NUM_PTS > COORD_W) begin : g_bad_en
      $error("gp_shadow_bank: enable mask wider than write data");
   end

   for (genvar k = 0; k < NUM_PTS; k++) begin : g_pt
      localparam int LO = k * COORD_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_fld[LO +: COORD_W] <= '0;
            sh_lin[LO +: COORD_W] <= '0;
            sh_pix[LO +: COORD_W] <= '0;
         end else if (wr_en) begin
            if (wr_addr == ADDR_W'(crd_addr(k, int'(CRD_FIELD))))
               sh_fld[LO +: COORD_W] <= wr_data;
            if (wr_addr == ADDR_W'(crd_addr(k, int'(CRD_LINE))))
               sh_lin[LO +: COORD_W] <= wr_data;
            if (wr_addr == ADDR_W'(crd_addr(k, int'(CRD_PIXEL))))
               sh_pix[LO +: COORD_W] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_en <= '0;
      else if (wr_en && wr_addr == ADDR_W'(EN_ADDR))
         sh_en <= wr_data[NUM_PTS-1:0];
   end

   // Active bank: refreshed only on the vertical-sync strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_fld <= '0;
         act_lin <= '0;
         act_pix <= '0;
         act_en  <= '0;
      end else if (vsync) begin
         act_fld <= sh_fld;
         act_lin <= sh_lin;
         act_pix <= sh_pix;
         act_en  <= sh_en;
      end
   end

   // R3: active bank holds between strobes
   a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync |=> ($stable(act_fld) && $stable(act_lin) && $stable(act_pix) && $stable(act_en)));

   // R3: strobe copies the shadow value present before the edge
   a_r3_active_load: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> (act_en == $past(sh_en) && act_pix == $past(sh_pix)
                 && act_lin == $past(sh_lin) && act_fld == $past(sh_fld)));

   // R2: unmapped addresses leave the shadow bank untouched
   a_r2_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr > ADDR_W'(EN_ADDR)) |=>
         ($stable(sh_fld) && $stable(sh_lin) && $stable(sh_pix) && $stable(sh_en)));

endmodule

// File: rtl/gp_match_unit.sv
module gp_match_unit #(
   parameter int NUM_PTS = 4,
   parameter int COORD_W = 13
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PTS*COORD_W-1:0] act_fld,
   input  logic [NUM_PTS*COORD_W-1:0] act_lin,
   input  logic [NUM_PTS*COORD_W-1:0] act_pix,
   input  logic [NUM_PTS-1:0]         act_en,
   input  logic [COORD_W-1:0]         fld_cnt,
   input  logic [COORD_W-1:0]         line_cnt,
   input  logic [COORD_W-1:0]         pix_cnt,
   output logic                       hit
);

   logic [NUM_PTS-1:0] eq_vec;

   for (genvar k = 0; k < NUM_PTS; k++) begin : g_cmp
      localparam int LO = k * COORD_W;
      assign eq_vec[k] = act_en[k]
                       && (act_fld[LO +: COORD_W] == fld_cnt)
                       && (act_lin[LO +: COORD_W] == line_cnt)
                       && (act_pix[LO +: COORD_W] == pix_cnt);
   end

   // Duplicate points collapse into a single hit (R6).
   assign hit = |eq_vec;

   // R4: a hit requires at least one enabled point
   a_r4_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (act_en != '0));

endmodule

// File: rtl/gp_toggle_gen.sv
module gp_toggle_gen #(
   parameter int  NUM_PTS = 4,
   parameter int  COORD_W = 13,
   localparam int ADDR_W  = $clog2(3 * NUM_PTS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vsync,
   input  logic [COORD_W-1:0] fld_cnt,
   input  logic [COORD_W-1:0] line_cnt,
   input  logic [COORD_W-1:0] pix_cnt,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [COORD_W-1:0] wr_data,
   output logic               wave_out
);

   if (NUM_PTS < 1) begin : g_bad_pts
      $error("gp_toggle_gen: NUM_PTS must be at least 1");
   end
   if (COORD_W < 2) begin : g_bad_w
      $error("gp_toggle_gen: COORD_W must be at least 2");
   end

   logic [NUM_PTS*COORD_W-1:0] act_fld, act_lin, act_pix;
   logic [NUM_PTS-1:0]         act_en;
   logic                       hit;

   gp_shadow_bank #(.NUM_PTS(NUM_PTS), .COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .vsync   (vsync),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .act_fld (act_fld),
      .act_lin (act_lin),
      .act_pix (act_pix),
      .act_en  (act_en)
   );

   gp_match_unit #(.NUM_PTS(NUM_PTS), .COORD_W(COORD_W)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_fld  (act_fld),
      .act_lin  (act_lin),
      .act_pix  (act_pix),
      .act_en   (act_en),
      .fld_cnt  (fld_cnt),
      .line_cnt (line_cnt),
      .pix_cnt  (pix_cnt),
      .hit      (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wave_out <= 1'b0;
      else if (vsync)
         wave_out <= 1'b0;
      else if (hit)
         wave_out <= ~wave_out;
   end

   // R5: strobe forces the output low
   a_r5_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> !wave_out);

   // R4/R8: a match outside the strobe inverts the output one edge later
   a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (!vsync && hit) |=> (wave_out != $past(wave_out)));

   // R7: no strobe and no match keeps the level
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!vsync && !hit) |=> $stable(wave_out));

endmodule

// File: tb/gp_toggle_gen_tb.sv
module gp_toggle_gen_tb;

   localparam int CLK_P   = 10;
   localparam int NPTS    = 4;
   localparam int CW      = 13;
   localparam int AW      = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vsync = 1'b0;
   logic [CW-1:0] fld_cnt = '0, line_cnt = '0, pix_cnt = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic          wave_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   gp_toggle_gen #(.NUM_PTS(NPTS), .COORD_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .vsync(vsync),
      .fld_cnt(fld_cnt), .line_cnt(line_cnt), .pix_cnt(pix_cnt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wave_out(wave_out)
   );

   // Bench model of both banks and the output
   logic [CW-1:0]   sh_c [NPTS][3];
   logic [CW-1:0]   ac_c [NPTS][3];
   logic [NPTS-1:0] sh_en = '0, ac_en = '0;
   logic            exp_wave = 1'b0;

   typedef struct {
      logic  exp;
      string tag;
   } item_t;
   item_t sb_q[$];

   initial begin
      for (int k = 0; k < NPTS; k++)
         for (int c = 0; c < 3; c++) begin
            sh_c[k][c] = '0;
            ac_c[k][c] = '0;
         end
   end

   task automatic step(input logic vs, input logic we, input logic [AW-1:0] a,
                       input logic [CW-1:0] d, input logic [CW-1:0] f,
                       input logic [CW-1:0] l, input logic [CW-1:0] p,
                       input string tag);
      logic  hit;
      item_t it;
      @(negedge clk);
      vsync = vs; wr_en = we; wr_addr = a; wr_data = d;
      fld_cnt = f; line_cnt = l; pix_cnt = p;
      hit = 1'b0;
      for (int k = 0; k < NPTS; k++)
         if (ac_en[k] && ac_c[k][0] == f && ac_c[k][1] == l && ac_c[k][2] == p)
            hit = 1'b1;
      if (vs) begin
         exp_wave = 1'b0;
         ac_c  = sh_c;
         ac_en = sh_en;
      end else if (hit) begin
         exp_wave = ~exp_wave;
      end
      if (we) begin
         if (a < 3 * NPTS) sh_c[a / 3][a % 3] = d;
         else if (a == 3 * NPTS) sh_en = d[NPTS-1:0];
      end
      it.exp = exp_wave;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d, input string tag);
      step(1'b0, 1'b1, a, d, 13'd5, 13'd5, 13'd5, tag);
   endtask

   task automatic vs_pulse(input string tag);
      step(1'b1, 1'b0, '0, '0, 13'd5, 13'd5, 13'd5, tag);
   endtask

   task automatic sweep(input int f, input int l, input int p0, input int p1, input string tag);
      for (int p = p0; p <= p1; p++)
         step(1'b0, 1'b0, '0, '0, CW'(f), CW'(l), CW'(p), tag);
   endtask

   // Monitor: compare each expected item just after the edge it belongs to
   initial begin
      item_t it;
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if (wave_out !== it.exp) begin
               fails++;
               $display("FAIL %s: wave_out=%0b expected=%0b at %0t", it.tag, wave_out, it.exp, $time);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: output low straight out of reset
      checks++;
      if (wave_out !== 1'b0) begin
         fails++;
         $display("FAIL R1: wave_out=%0b expected=0", wave_out);
      end
      // R1: zero points are disabled, counters at origin do nothing
      vs_pulse("R1");
      sweep(0, 0, 0, 3, "R1");
      // R2: program point0 (0,2,5), point1 (0,2,9), enable both
      wr(4'd0, 13'd0, "R2"); wr(4'd1, 13'd2, "R2"); wr(4'd2, 13'd5, "R2");
      wr(4'd3, 13'd0, "R2"); wr(4'd4, 13'd2, "R2"); wr(4'd5, 13'd9, "R2");
      wr(4'd12, 13'd3, "R2");
      // R3: nothing active before the strobe
      sweep(0, 2, 0, 12, "R3");
      vs_pulse("R3");
      // R4/R8: toggles at pixel 5 and 9
      sweep(0, 2, 0, 12, "R4");
      sweep(0, 3, 4, 10, "R8");
      // R6: point2 duplicates point0
      wr(4'd6, 13'd0, "R6"); wr(4'd7, 13'd2, "R6"); wr(4'd8, 13'd5, "R6");
      wr(4'd12, 13'd7, "R6");
      vs_pulse("R6");
      sweep(0, 2, 0, 12, "R6");
      // R4: only point1 enabled
      wr(4'd12, 13'd2, "R4");
      vs_pulse("R4");
      sweep(0, 2, 0, 12, "R4");
      // R2: unmapped address write has no effect
      wr(4'd13, 13'h1FFF, "R2"); wr(4'd15, 13'h0155, "R2");
      vs_pulse("R2");
      sweep(0, 2, 0, 12, "R2");
      // R5: strobe coinciding with a match clears the output
      step(1'b1, 1'b0, '0, '0, 13'd0, 13'd2, 13'd9, "R5");
      sweep(0, 2, 8, 9, "R5");
      vs_pulse("R5");
      // point3 at the top of the coordinate range
      wr(4'd9, 13'd1, "R2"); wr(4'd10, 13'd8191, "R2"); wr(4'd11, 13'd8191, "R2");
      // R3: write in the strobe cycle waits for the next strobe
      step(1'b1, 1'b1, 4'd12, 13'd15, 13'd5, 13'd5, 13'd5, "R3");
      sweep(0, 2, 0, 12, "R3");
      sweep(1, 8191, 8189, 8191, "R3");
      vs_pulse("R3");
      sweep(1, 8191, 8189, 8191, "R4");
      sweep(0, 2, 0, 12, "R6");
      // R7: idle holds
      sweep(7, 7, 0, 6, "R7");
      vs_pulse("R7");
      sweep(7, 7, 0, 3, "R7");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule